// File: doc/BRIEF.md
# Write Coalescing Hold Table

This block decides whether a pending partial-line write miss should be held back so that the rest of its cache line can arrive and merge into a single whole-line request. It keeps a small, fully associative table of per-line retry budgets, each keyed by block address. A streaming-write detector sits next to it and sends two strobes. The continue strobe fires when a write extends the current stream and refills the budget for that write's line. The restart strobe fires when a write breaks the stream and drops the line's entry.

When the miss queue is about to send a request, it presents an issue query. The answer comes back in the same cycle and is one of three outcomes. The first is to hold the request for a number of cycles equal to the line size divided by the write size. The second is to issue it normally. The third is to issue it and tell the detector to fall back to its plain allocate mode. Each hold uses up one unit of that line's budget, so a line can only be held a bounded number of times.

Top module: `wc_hold_table`

## Requirements
- R1: A continue strobe loads the named block's budget with THRESH (default 8). With no further strobes for that block, exactly THRESH consecutive partial-write queries to it are answered with hold, and the next one is not.
- R2: An active partial-write query whose block has a nonzero budget raises rsp_hold, leaves rsp_issue low and lowers that budget by one. A block with a zero budget or no entry is answered with rsp_issue.
- R3: While rsp_hold is high, rsp_hold_cycles equals 2^(LINE_LOG2 - qry_size_log2), where qry_size_log2 is log2 of the write size in bytes (64-byte line: size code 3 gives 8, size code 0 gives 64). A size code of LINE_LOG2 or more gives 1.
- R4: A query made while mode_coalesce is low, or while qry_is_write is low, is answered with rsp_issue only (no hold, no mode reset). It leaves the table unchanged.
- R5: An active query with qry_full_line high is answered with rsp_issue only and erases that block's entry.
- R6: An active partial-write query answered without a hold raises rsp_mode_reset together with rsp_issue.
- R7: A restart strobe erases the entry for its block, so a following partial-write query to that block is answered with rsp_issue and rsp_mode_reset.
- R8: The table holds ENTRIES (default 8) lines. A continue strobe that misses the table takes the lowest-numbered free slot. If no slot is free, it replaces the entry with the most allocations since its own, which with distinct loads is the oldest one. Other entries are not disturbed.
- R9: When a continue strobe and a query name the same block in the same cycle, the query sees the freshly loaded budget. It is answered with hold, and THRESH-1 further holds follow.
- R10: When a continue strobe and a restart strobe name the same block in the same cycle, the load wins and the entry keeps a full budget.
- R11: When qry_vld is low, rsp_issue, rsp_hold and rsp_mode_reset are all low. The response is combinational in the query cycle, and table updates take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, empties the table |
| cont_vld | input | 1 | Stream-continue strobe from the detector |
| cont_blk | input | BLK_W | Block address for the continue strobe |
| restart_vld | input | 1 | Stream-restart strobe from the detector |
| restart_blk | input | BLK_W | Block address for the restart strobe |
| qry_vld | input | 1 | Issue query valid |
| qry_blk | input | BLK_W | Block address of the pending request |
| qry_is_write | input | 1 | Pending request is a write |
| qry_full_line | input | 1 | Pending write already covers the whole line |
| qry_size_log2 | input | SZ_W | log2 of the write size in bytes |
| mode_coalesce | input | 1 | Detector reports coalescing mode |
| rsp_issue | output | 1 | Send the request now |
| rsp_hold | output | 1 | Hold the request |
| rsp_hold_cycles | output | HOLD_W | Hold length in cycles, valid with rsp_hold |
| rsp_mode_reset | output | 1 | Tell the detector to return to allocate mode |

## Verification
Directed sequences cover the cases that need exact counts. These are a budget drained to zero, a whole-line query that erases its entry, and a restart that drops an entry. They also cover a same-cycle load and query, a same-cycle load and restart, and a full table forced to evict its oldest line. Random traffic over a pool of twelve blocks, larger than the table, mixes every strobe and query kind with all size codes. It separates eviction order and budget bookkeeping from the plain decision logic, because a mistake in either shows up later as a wrong hold or issue on some other line. Bypass queries, made outside coalescing mode or for reads, are followed by active queries to the same block, so any stray change they make to the table becomes visible.

// File: rtl/wc_hold_pkg.sv
package wc_hold_pkg;

   typedef enum logic [1:0] {
      DEC_NONE      = 2'd0,
      DEC_ISSUE     = 2'd1,
      DEC_HOLD      = 2'd2,
      DEC_ISSUE_RST = 2'd3
   } hold_dec_e;

endpackage

// File: rtl/wc_hold_len.sv
module wc_hold_len #(
   parameter int LINE_LOG2 = 6,
   parameter int SZ_W      = 3,
   parameter int HOLD_W    = 7
) (
   input  logic [SZ_W-1:0]   size_log2,
   output logic [HOLD_W-1:0] hold_len
);

   generate
      if (LINE_LOG2 == 0) begin : g_unit_line
         assign hold_len = HOLD_W'(1);
      end else begin : g_shift
         localparam logic [SZ_W-1:0] LINE_CODE = SZ_W'(LINE_LOG2);
         logic [SZ_W-1:0] gap;
         always_comb begin
            gap = LINE_CODE - size_log2;
            if (size_log2 >= LINE_CODE) hold_len = HOLD_W'(1);
            else                        hold_len = HOLD_W'(1) << gap;
         end
      end
   endgenerate

endmodule

// File: rtl/wc_victim_pick.sv
module wc_victim_pick #(
   parameter int ENTRIES = 8,
   parameter int AGE_W   = 3,
   parameter int IDX_W   = 3
) (
   input  logic [ENTRIES-1:0]            valid,
   input  logic [ENTRIES-1:0][AGE_W-1:0] age,
   output logic [IDX_W-1:0]              pick
);

   logic             have_free;
   logic [IDX_W-1:0] free_idx;
   logic [IDX_W-1:0] old_idx;
   logic [AGE_W-1:0] old_age;

   always_comb begin
      have_free = 1'b0;
      free_idx  = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid[i]) begin
            have_free = 1'b1;
            free_idx  = IDX_W'(i);
         end
      end
   end

   always_comb begin
      old_idx = '0;
      old_age = age[0];
      for (int i = 1; i < ENTRIES; i++) begin
         if (age[i] > old_age) begin
            old_age = age[i];
            old_idx = IDX_W'(i);
         end
      end
   end

   assign pick = have_free ? free_idx : old_idx;

endmodule

// File: rtl/wc_hold_slot.sv
module wc_hold_slot #(
   parameter int BLK_W  = 26,
   parameter int CNT_W  = 4,
   parameter int AGE_W  = 3,
   parameter int THRESH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_hit,
   input  logic             ld_hit,
   input  logic             ld_alloc,
   input  logic [BLK_W-1:0] ld_blk,
   input  logic             age_inc,
   input  logic             q_dec,
   input  logic             q_erase,
   output logic             valid,
   output logic [BLK_W-1:0] tag,
   output logic [AGE_W-1:0] age,
   output logic             eff_valid,
   output logic [BLK_W-1:0] eff_tag,
   output logic [CNT_W-1:0] eff_cnt
);

   localparam logic [AGE_W-1:0] AGE_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_LD  = CNT_W'(THRESH);

   logic [CNT_W-1:0] cnt;

   // state as seen after this cycle's strobes; load beats restart
   always_comb begin
      eff_valid = valid;
      eff_tag   = tag;
      eff_cnt   = cnt;
      if (ld_hit || ld_alloc) begin
         eff_valid = 1'b1;
         eff_tag   = ld_blk;
         eff_cnt   = CNT_LD;
      end else if (clr_hit) begin
         eff_valid = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         tag   <= '0;
         cnt   <= '0;
         age   <= '0;
      end else begin
         valid <= eff_valid && !q_erase;
         tag   <= eff_tag;
         cnt   <= q_dec ? eff_cnt - 1'b1 : eff_cnt;
         if (ld_alloc)                      age <= '0;
         else if (age_inc && age != AGE_MAX) age <= age + 1'b1;
      end
   end

   p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> cnt <= CNT_LD);

   p_dec_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      q_dec |-> eff_cnt != '0);

   p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_hit || ld_alloc) && !q_erase |=> valid && tag == $past(ld_blk));

endmodule

// File: rtl/wc_hold_table.sv
module wc_hold_table #(
   parameter int ENTRIES   = 8,
   parameter int BLK_W     = 26,
   parameter int CNT_W     = 4,
   parameter int THRESH    = 8,
   parameter int LINE_LOG2 = 6,
   parameter int SZ_W      = $clog2(LINE_LOG2 + 2),
   parameter int HOLD_W    = LINE_LOG2 + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cont_vld,
   input  logic [BLK_W-1:0]  cont_blk,
   input  logic              restart_vld,
   input  logic [BLK_W-1:0]  restart_blk,
   input  logic              qry_vld,
   input  logic [BLK_W-1:0]  qry_blk,
   input  logic              qry_is_write,
   input  logic              qry_full_line,
   input  logic [SZ_W-1:0]   qry_size_log2,
   input  logic              mode_coalesce,
   output logic              rsp_issue,
   output logic              rsp_hold,
   output logic [HOLD_W-1:0] rsp_hold_cycles,
   output logic              rsp_mode_reset
);
   import wc_hold_pkg::*;

   localparam int IDX_W = $clog2(ENTRIES);
   localparam int AGE_W = IDX_W;

   generate
      if (ENTRIES < 2)               begin : g_bad_entries $error("ENTRIES must be at least 2"); end
      if (THRESH < 2)                begin : g_bad_thresh  $error("THRESH must be at least 2"); end
      if (THRESH >= (1 << CNT_W))    begin : g_bad_cnt     $error("THRESH does not fit CNT_W"); end
      if ((1 << SZ_W) <= LINE_LOG2)  begin : g_bad_sz      $error("SZ_W too narrow"); end
   endgenerate

   logic [ENTRIES-1:0]            s_valid, e_valid;
   logic [ENTRIES-1:0][BLK_W-1:0] s_tag, e_tag;
   logic [ENTRIES-1:0][AGE_W-1:0] s_age;
   logic [ENTRIES-1:0][CNT_W-1:0] e_cnt;
   logic [ENTRIES-1:0]            ld_hit, ld_alloc, clr_hit, q_match, q_dec, q_erase;
   logic [IDX_W-1:0]              vict_idx;
   logic                          do_alloc, clr_same;
   logic [CNT_W-1:0]              q_cnt;
   logic                          q_active, q_partial;
   logic [HOLD_W-1:0]             len_raw;
   hold_dec_e                     dec;

   assign do_alloc = cont_vld && !(|ld_hit);
   assign clr_same = cont_vld && (cont_blk == restart_blk);

   wc_victim_pick #(.ENTRIES(ENTRIES), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_vict (
      .valid (s_valid),
      .age   (s_age),
      .pick  (vict_idx)
   );

   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
         assign ld_hit[g]   = cont_vld && s_valid[g] && (s_tag[g] == cont_blk);
         assign ld_alloc[g] = do_alloc && (vict_idx == IDX_W'(g));
         assign clr_hit[g]  = restart_vld && !clr_same && s_valid[g] && (s_tag[g] == restart_blk);
         assign q_match[g]  = qry_vld && e_valid[g] && (e_tag[g] == qry_blk);
         assign q_dec[g]    = (dec == DEC_HOLD) && q_match[g];
         assign q_erase[g]  = q_active && qry_full_line && q_match[g];

         wc_hold_slot #(.BLK_W(BLK_W), .CNT_W(CNT_W), .AGE_W(AGE_W), .THRESH(THRESH)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_hit   (clr_hit[g]),
            .ld_hit    (ld_hit[g]),
            .ld_alloc  (ld_alloc[g]),
            .ld_blk    (cont_blk),
            .age_inc   (do_alloc),
            .q_dec     (q_dec[g]),
            .q_erase   (q_erase[g]),
            .valid     (s_valid[g]),
            .tag       (s_tag[g]),
            .age       (s_age[g]),
            .eff_valid (e_valid[g]),
            .eff_tag   (e_tag[g]),
            .eff_cnt   (e_cnt[g])
         );
      end
   endgenerate

   always_comb begin
      q_cnt = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (q_match[i]) q_cnt = q_cnt | e_cnt[i];
      end
   end

   assign q_active  = qry_vld && mode_coalesce && qry_is_write;
   assign q_partial = q_active && !qry_full_line;

   always_comb begin
      if (!qry_vld)                    dec = DEC_NONE;
      else if (!q_partial)             dec = DEC_ISSUE;
      else if (q_cnt != '0)            dec = DEC_HOLD;
      else                             dec = DEC_ISSUE_RST;
   end

   wc_hold_len #(.LINE_LOG2(LINE_LOG2), .SZ_W(SZ_W), .HOLD_W(HOLD_W)) u_len (
      .size_log2 (qry_size_log2),
      .hold_len  (len_raw)
   );

   assign rsp_issue       = (dec == DEC_ISSUE) || (dec == DEC_ISSUE_RST);
   assign rsp_hold        = (dec == DEC_HOLD);
   assign rsp_mode_reset  = (dec == DEC_ISSUE_RST);
   assign rsp_hold_cycles = rsp_hold ? len_raw : '0;

   p_one_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
      qry_vld |-> $countones({rsp_issue, rsp_hold}) == 1 && (!rsp_mode_reset || rsp_issue));

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !qry_vld |-> !rsp_issue && !rsp_hold && !rsp_mode_reset);

   p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      qry_vld && !(mode_coalesce && qry_is_write) |-> rsp_issue && !rsp_mode_reset);

   p_full_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
      qry_vld && mode_coalesce && qry_is_write && qry_full_line |-> rsp_issue && !rsp_mode_reset);

   p_hold_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hold |-> $onehot(rsp_hold_cycles));

   p_unique_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(q_match));

   p_load_then_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cont_vld) && !$past(qry_vld) && !cont_vld && !restart_vld &&
      qry_vld && mode_coalesce && qry_is_write && !qry_full_line &&
      qry_blk == $past(cont_blk) |-> rsp_hold);

endmodule

// File: tb/sim_wc_hold_table.sv
`timescale 1ns/1ps
module sim_wc_hold_table;

   localparam int N      = 8;
   localparam int BW     = 26;
   localparam int TH     = 8;
   localparam int LL     = 6;
   localparam int SZW    = 3;
   localparam int HW     = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cont_vld = 1'b0, restart_vld = 1'b0, qry_vld = 1'b0;
   logic [BW-1:0] cont_blk = '0, restart_blk = '0, qry_blk = '0;
   logic          qry_is_write = 1'b0, qry_full_line = 1'b0, mode_coalesce = 1'b0;
   logic [SZW-1:0] qry_size_log2 = '0;
   logic          rsp_issue, rsp_hold, rsp_mode_reset;
   logic [HW-1:0] rsp_hold_cycles;

   int checks = 0, errors = 0;
   bit done = 0;

   int m_v[N], m_t[N], m_c[N], m_a[N];
   bit ob_i, ob_h, ob_r; int ob_l;
   bit ex_i, ex_h, ex_r; int ex_l;
   string ex_req;

   always #10 clk = ~clk;

   wc_hold_table u0 (
      .clk(clk), .rst_n(rst_n),
      .cont_vld(cont_vld), .cont_blk(cont_blk),
      .restart_vld(restart_vld), .restart_blk(restart_blk),
      .qry_vld(qry_vld), .qry_blk(qry_blk), .qry_is_write(qry_is_write),
      .qry_full_line(qry_full_line), .qry_size_log2(qry_size_log2),
      .mode_coalesce(mode_coalesce),
      .rsp_issue(rsp_issue), .rsp_hold(rsp_hold),
      .rsp_hold_cycles(rsp_hold_cycles), .rsp_mode_reset(rsp_mode_reset)
   );

   function automatic int exp_len(int sz);
      return (sz >= LL) ? 1 : (1 << (LL - sz));
   endfunction

   task automatic check(bit ok, string req, string what, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic chk_out(string req, bit i, bit h, bit r);
      check(ob_i == i && ob_h == h && ob_r == r, req, "issue/hold/reset",
            {ob_i, ob_h, ob_r}, {i, h, r});
   endtask

   task automatic model_clear();
      for (int i = 0; i < N; i++) begin m_v[i] = 0; m_t[i] = 0; m_c[i] = 0; m_a[i] = 0; end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cont_vld = 0; restart_vld = 0; qry_vld = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_clear();
   endtask

   // one cycle: drive, sample the combinational answer, advance the model
   task automatic step(bit lv, int lb, bit cv, int cb, bit qv, int qb,
                       bit qw, bit qf, int qs, bit co);
      int e_v[N], e_t[N], e_c[N];
      int hit, alloc, qh, best;
      bit act;
      @(negedge clk);
      cont_vld = lv; cont_blk = BW'(lb);
      restart_vld = cv; restart_blk = BW'(cb);
      qry_vld = qv; qry_blk = BW'(qb); qry_is_write = qw;
      qry_full_line = qf; qry_size_log2 = SZW'(qs); mode_coalesce = co;
      #5;
      ob_i = rsp_issue; ob_h = rsp_hold; ob_r = rsp_mode_reset; ob_l = int'(rsp_hold_cycles);
      hit = -1; alloc = -1;
      for (int i = 0; i < N; i++) if (m_v[i] != 0 && m_t[i] == lb) hit = i;
      if (lv && hit < 0) begin
         for (int i = N - 1; i >= 0; i--) if (m_v[i] == 0) alloc = i;
         if (alloc < 0) begin
            alloc = 0; best = m_a[0];
            for (int i = 1; i < N; i++) if (m_a[i] > best) begin best = m_a[i]; alloc = i; end
         end
      end
      for (int i = 0; i < N; i++) begin
         e_v[i] = m_v[i]; e_t[i] = m_t[i]; e_c[i] = m_c[i];
         if (lv && (i == hit || i == alloc)) begin e_v[i] = 1; e_t[i] = lb; e_c[i] = TH; end
         else if (cv && !(lv && lb == cb) && m_v[i] != 0 && m_t[i] == cb) e_v[i] = 0;
      end
      qh = -1;
      for (int i = 0; i < N; i++) if (qv && e_v[i] != 0 && e_t[i] == qb) qh = i;
      act = qv && co && qw;
      ex_i = 0; ex_h = 0; ex_r = 0; ex_l = 0;
      if (!qv)                      ex_req = "R11";
      else if (!act)                begin ex_req = "R4"; ex_i = 1; end
      else if (qf)                  begin ex_req = "R5"; ex_i = 1; end
      else if (qh >= 0 && e_c[qh] > 0) begin ex_req = "R2"; ex_h = 1; ex_l = exp_len(qs); end
      else                          begin ex_req = "R6"; ex_i = 1; ex_r = 1; end
      if (ex_h) e_c[qh] = e_c[qh] - 1;
      if (act && qf && qh >= 0) e_v[qh] = 0;
      for (int i = 0; i < N; i++) begin
         m_v[i] = e_v[i]; m_t[i] = e_t[i]; m_c[i] = e_c[i];
         if (alloc >= 0) begin
            if (i == alloc) m_a[i] = 0;
            else if (m_a[i] < N - 1) m_a[i] = m_a[i] + 1;
         end
      end
   endtask

   task automatic load(int b);   step(1, b, 0, 0, 0, 0, 0, 0, 0, 0); endtask
   task automatic query(int b, int sz); step(0, 0, 0, 0, 1, b, 1, 0, sz, 1); endtask

   task automatic count_holds(int b, output int n);
      n = 0;
      for (int k = 0; k < 20; k++) begin
         query(b, 3);
         if (!ob_h) break;
         n++;
      end
   endtask

   initial begin
      int n;
      do_reset();
      // R11: idle after reset
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
      chk_out("R11", 0, 0, 0);
      // R6: empty table
      query(5, 3);
      chk_out("R6", 1, 0, 1);
      // R1 / R2: budget drains in THRESH holds
      load(10);
      query(10, 3);
      chk_out("R2", 0, 1, 0);
      check(ob_l == 8, "R3", "len size3", ob_l, 8);
      count_holds(10, n);
      check(n == TH - 1, "R1", "holds after load", n + 1, TH);
      chk_out("R6", 1, 0, 1);
      // R3: hold lengths
      load(11);
      query(11, 0); check(ob_h && ob_l == 64, "R3", "len size0", ob_l, 64);
      query(11, 6); check(ob_h && ob_l == 1, "R3", "len size6", ob_l, 1);
      query(11, 7); check(ob_h && ob_l == 1, "R3", "len size7", ob_l, 1);
      // R4: bypass queries leave the budget alone
      load(12);
      step(0, 0, 0, 0, 1, 12, 1, 0, 3, 0); chk_out("R4", 1, 0, 0);
      step(0, 0, 0, 0, 1, 12, 0, 0, 3, 1); chk_out("R4", 1, 0, 0);
      count_holds(12, n);
      check(n == TH, "R4", "budget untouched", n, TH);
      // R5: whole line erases
      load(13);
      step(0, 0, 0, 0, 1, 13, 1, 1, 3, 1); chk_out("R5", 1, 0, 0);
      query(13, 3); chk_out("R5", 1, 0, 1);
      // R7: restart erases
      load(14);
      step(0, 0, 1, 14, 0, 0, 0, 0, 0, 0);
      query(14, 3); chk_out("R7", 1, 0, 1);
      // R9: same-cycle load and query
      step(1, 15, 0, 0, 1, 15, 1, 0, 3, 1); chk_out("R9", 0, 1, 0);
      count_holds(15, n);
      check(n == TH - 1, "R9", "holds after same-cycle", n, TH - 1);
      // R10: load beats restart
      step(1, 16, 1, 16, 0, 0, 0, 0, 0, 0);
      query(16, 3); chk_out("R10", 0, 1, 0);
      // R8: eviction of oldest, free-slot reuse
      do_reset();
      for (int b = 100; b < 108; b++) load(b);
      load(108);
      query(100, 3); chk_out("R8", 1, 0, 1);
      query(101, 3); chk_out("R8", 0, 1, 0);
      query(108, 3); chk_out("R8", 0, 1, 0);
      step(0, 0, 1, 102, 0, 0, 0, 0, 0, 0);
      load(109);
      query(103, 3); chk_out("R8", 0, 1, 0);
      query(109, 3); chk_out("R8", 0, 1, 0);
      // random traffic against the bench model
      void'($urandom(32'h5eed_1234));
      for (int c = 0; c < 4000; c++) begin
         bit lv, cv, qv, qw, qf, co;
         int lb, cb, qb, qs;
         lv = ($urandom % 10) < 4;  lb = 200 + $urandom % 12;
         cv = ($urandom % 10) < 2;  cb = 200 + $urandom % 12;
         qv = ($urandom % 10) < 7;  qb = 200 + $urandom % 12;
         qw = ($urandom % 10) < 8;  co = ($urandom % 10) < 8;
         qf = ($urandom % 10) < 1;  qs = $urandom % 8;
         step(lv, lb, cv, cb, qv, qb, qw, qf, qs, co);
         chk_out(ex_req, ex_i, ex_h, ex_r);
         if (ex_h) check(ob_l == ex_l, "R3", "random len", ob_l, ex_l);
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule